// File: doc/BRIEF.md
# Streaming Packet Protocol Checker

This block sits passively beside a packet stream that carries valid, start-of-packet, end-of-packet, an empty-lane count and a channel number, with an optional ready from the sink. It never drives the bus. Each accepted beat is tracked: the block works out how many bytes every packet holds, remembers which channel the packet came on, and reports both with a one-cycle done strobe when the packet ends.

While it tracks packets it also watches for framing faults. It catches a second start while a packet is still open, a beat that belongs to no packet, a channel that shifts partway through a packet, a channel number above the highest one allowed, and a packet that stalls for too long. Each fault sets its own bit in an error vector, and the bit stays set until reset. A system integrator places the checker on a link under test and reads the error vector and the length reports.

Top module: `stream_proto_checker`

## Requirements
- R1: A beat counts only when `bus_valid` is high and, with `HAS_READY`=1, `bus_ready` is also high. A beat with ready low changes no output and no state.
- R2: A beat that is not the end of a packet carries `DATA_W/8` bytes. The end-of-packet beat carries `DATA_W/8 - bus_empty` bytes, because the unused lanes are the low-order ones (the first byte sits in the top bits). `bus_empty` is ignored on other beats.
- R3: The cycle after the edge that accepts an end-of-packet beat of an open or just-starting packet, `pkt_done` is high for one cycle. `pkt_len` then gives the packet's byte total and `pkt_chan` its channel. Both keep their values until the next done.
- R4: An accepted start while a packet is open sets `proto_err[0]`. The new start then opens a fresh packet.
- R5: An accepted beat with no start while no packet is open sets `proto_err[1]`. The beat is not counted and does not raise done.
- R6: A continuing beat whose channel differs from the one captured at the start sets `proto_err[2]`.
- R7: A start beat whose channel is greater than `MAX_CHANNEL` sets `proto_err[3]`.
- R8: While a packet is open, cycles without an accepted beat are counted. When the count reaches a non-zero `stall_limit`, `proto_err[4]` is set. A `stall_limit` of zero disables this check.
- R9: Every accepted beat clears the stall count. An end-of-packet beat closes the packet, and the stall count then stays at zero.
- R10: Error bits stay set until reset. Synchronous reset clears all outputs and state, and no error is raised while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Observed beat valid |
| bus_ready | input | 1 | Observed sink ready (ignored when HAS_READY=0) |
| bus_sop | input | 1 | Observed start of packet |
| bus_eop | input | 1 | Observed end of packet |
| bus_empty | input | EMPTY_W | Unused low-order byte lanes on the end beat |
| bus_channel | input | CH_W | Observed channel number |
| stall_limit | input | TO_W | Stall timeout in cycles, 0 disables it |
| pkt_done | output | 1 | One-cycle strobe per completed packet |
| pkt_len | output | LEN_W | Byte length of the last completed packet |
| pkt_chan | output | CH_W | Channel of the last completed packet |
| proto_err | output | 5 | Sticky error bits: 0 duplicate start, 1 stray beat, 2 channel change, 3 channel too high, 4 stall |

## Verification
The bench builds the checker with a 32-bit word, which gives four byte lanes and a 2-bit empty field. It uses a 3-bit channel with `MAX_CHANNEL`=5, so channels 6 and 7 can trip the range check. Ready is enabled, so ignored beats under backpressure are exercised. The stall limit is a run-time input, so the same build covers a disabled limit, a stall that ends one cycle short of the limit, and one that reaches it exactly.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int ERR_W     = 5;
  localparam int ERR_DUP   = 0;
  localparam int ERR_OUT   = 1;
  localparam int ERR_CHG   = 2;
  localparam int ERR_OVR   = 3;
  localparam int ERR_STALL = 4;
endpackage

// File: rtl/spc_beat_decode.sv
module spc_beat_decode #(
  parameter int BYTES     = 4,
  parameter int EMPTY_W   = 2,
  parameter int LEN_W     = 16,
  parameter bit HAS_READY = 1'b1
) (
  input  logic               valid_i,
  input  logic               ready_i,
  input  logic               eop_i,
  input  logic [EMPTY_W-1:0] empty_i,
  output logic               accept_o,
  output logic [LEN_W-1:0]   bytes_o
);
  generate
    if (HAS_READY) begin : g_rdy
      assign accept_o = valid_i & ready_i;
    end else begin : g_nordy
      logic unused_rdy;
      assign unused_rdy = ready_i;
      assign accept_o = valid_i;
    end
  endgenerate

  // The low-order lanes are the unused ones on the last beat
  always_comb begin
    if (eop_i) bytes_o = LEN_W'(BYTES) - LEN_W'(empty_i);
    else       bytes_o = LEN_W'(BYTES);
  end
endmodule

// File: rtl/spc_pkt_tracker.sv
module spc_pkt_tracker #(
  parameter int LEN_W       = 16,
  parameter int CH_W        = 3,
  parameter int MAX_CHANNEL = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [LEN_W-1:0] beat_bytes_i,
  output logic             open_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             ev_dup_o,
  output logic             ev_out_o,
  output logic             ev_chg_o,
  output logic             ev_ovr_o
);
  logic             open_q;
  logic [LEN_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic             in_pkt;
  logic [LEN_W-1:0] cnt_nx;
  logic [CH_W-1:0]  ch_nx;

  assign in_pkt = sop_i | open_q;
  assign cnt_nx = sop_i ? beat_bytes_i : cnt_q + beat_bytes_i;
  assign ch_nx  = sop_i ? chan_i : ch_q;

  assign ev_dup_o = accept_i & sop_i & open_q;
  assign ev_out_o = accept_i & ~sop_i & ~open_q;
  assign ev_chg_o = accept_i & ~sop_i & open_q & (chan_i != ch_q);
  assign ev_ovr_o = accept_i & sop_i & (int'(chan_i) > MAX_CHANNEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      ch_q   <= '0;
      done_o <= 1'b0;
      len_o  <= '0;
      chan_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_i && in_pkt) begin
        cnt_q <= cnt_nx;
        ch_q  <= ch_nx;
        if (eop_i) begin
          open_q <= 1'b0;
          done_o <= 1'b1;
          len_o  <= cnt_nx;
          chan_o <= ch_nx;
        end else begin
          open_q <= 1'b1;
        end
      end
    end
  end

  assign open_o = open_q;

  assert_done_after_eop_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(accept_i && eop_i));
  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (len_o != '0));
endmodule

// File: rtl/spc_stall_watch.sv
module spc_stall_watch #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            open_i,
  input  logic            accept_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            ev_stall_o
);
  logic [TO_W-1:0] idle_q;
  logic [TO_W:0]   idle_nx;

  assign idle_nx = {1'b0, idle_q} + (TO_W+1)'(1);
  assign ev_stall_o = open_i & ~accept_i & (limit_i != '0) &
                      (idle_nx >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst || accept_i || !open_i) idle_q <= '0;
    else if (idle_q != {TO_W{1'b1}}) idle_q <= idle_nx[TO_W-1:0];
  end

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> (idle_q == '0));
endmodule

// File: rtl/stream_proto_checker.sv
module stream_proto_checker
  import spc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CH_W        = 3,
  parameter int MAX_CHANNEL = 5,
  parameter int LEN_W       = 16,
  parameter int TO_W        = 8,
  parameter bit HAS_READY   = 1'b1,
  localparam int BYTES      = DATA_W / 8,
  localparam int EMPTY_W    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_ready,
  input  logic               bus_sop,
  input  logic               bus_eop,
  input  logic [EMPTY_W-1:0] bus_empty,
  input  logic [CH_W-1:0]    bus_channel,
  input  logic [TO_W-1:0]    stall_limit,
  output logic               pkt_done,
  output logic [LEN_W-1:0]   pkt_len,
  output logic [CH_W-1:0]    pkt_chan,
  output logic [ERR_W-1:0]   proto_err
);
  logic             accept;
  logic [LEN_W-1:0] beat_bytes;
  logic             pkt_open;
  logic             ev_dup, ev_out, ev_chg, ev_ovr, ev_stall;
  logic [ERR_W-1:0] ev_vec;
  logic [ERR_W-1:0] err_q;

  spc_beat_decode #(
    .BYTES(BYTES), .EMPTY_W(EMPTY_W), .LEN_W(LEN_W), .HAS_READY(HAS_READY)
  ) i_decode (
    .valid_i(bus_valid), .ready_i(bus_ready), .eop_i(bus_eop),
    .empty_i(bus_empty), .accept_o(accept), .bytes_o(beat_bytes)
  );

  spc_pkt_tracker #(
    .LEN_W(LEN_W), .CH_W(CH_W), .MAX_CHANNEL(MAX_CHANNEL)
  ) i_track (
    .clk(clk), .rst(rst), .accept_i(accept), .sop_i(bus_sop),
    .eop_i(bus_eop), .chan_i(bus_channel), .beat_bytes_i(beat_bytes),
    .open_o(pkt_open), .done_o(pkt_done), .len_o(pkt_len), .chan_o(pkt_chan),
    .ev_dup_o(ev_dup), .ev_out_o(ev_out), .ev_chg_o(ev_chg), .ev_ovr_o(ev_ovr)
  );

  spc_stall_watch #(.TO_W(TO_W)) i_stall (
    .clk(clk), .rst(rst), .open_i(pkt_open), .accept_i(accept),
    .limit_i(stall_limit), .ev_stall_o(ev_stall)
  );

  always_comb begin
    ev_vec            = '0;
    ev_vec[ERR_DUP]   = ev_dup;
    ev_vec[ERR_OUT]   = ev_out;
    ev_vec[ERR_CHG]   = ev_chg;
    ev_vec[ERR_OVR]   = ev_ovr;
    ev_vec[ERR_STALL] = ev_stall;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_q | ev_vec;
  end

  assign proto_err = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (proto_err != '0) |=> ((proto_err & $past(proto_err)) == $past(proto_err)));
  assert_stray_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err[ERR_OUT]) |-> $past(bus_valid && !bus_sop));
  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err[ERR_STALL]) |-> $past(stall_limit != '0));
  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err[ERR_OVR]) |-> $past(bus_sop && (int'(bus_channel) > MAX_CHANNEL)));
endmodule

// File: tb/test_stream_proto_checker.sv
module test_stream_proto_checker;
  localparam int MAXC = 5;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v = 0, r = 0, s = 0, e = 0;
  logic [1:0] emp = 0;
  logic [2:0] ch = 0;
  logic [7:0] tmo = 0;
  logic pkt_done;
  logic [15:0] pkt_len;
  logic [2:0] pkt_chan;
  logic [4:0] proto_err;

  int n_chk = 0, n_bad = 0;
  // reference model state
  int m_open = 0, m_cnt = 0, m_ch = 0, m_idle = 0;
  int m_done = 0, m_len = 0, m_pch = 0;
  bit [4:0] m_err = 0;

  always #5 clk = ~clk;

  stream_proto_checker #(.DATA_W(32), .CH_W(3), .MAX_CHANNEL(MAXC),
    .LEN_W(16), .TO_W(8), .HAS_READY(1'b1)) i_stream_proto_checker (
    .clk(clk), .rst(rst), .bus_valid(v), .bus_ready(r), .bus_sop(s),
    .bus_eop(e), .bus_empty(emp), .bus_channel(ch), .stall_limit(tmo),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_chan(pkt_chan),
    .proto_err(proto_err));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int acc, bb, inpkt;
    if (rst) begin
      m_open = 0; m_cnt = 0; m_ch = 0; m_idle = 0;
      m_done = 0; m_len = 0; m_pch = 0; m_err = 0;
    end else begin
      acc = (v && r) ? 1 : 0;
      bb = e ? 4 - int'(emp) : 4;
      m_done = 0;
      if (acc != 0) begin
        inpkt = (s || m_open != 0) ? 1 : 0;
        if (s) begin
          if (m_open != 0) m_err[0] = 1;
          m_cnt = bb; m_ch = int'(ch); m_open = 1;
          if (int'(ch) > MAXC) m_err[3] = 1;
        end else if (m_open == 0) begin
          m_err[1] = 1;
        end else begin
          if (int'(ch) != m_ch) m_err[2] = 1;
          m_cnt += bb;
        end
        if (e && inpkt != 0) begin
          m_done = 1; m_len = m_cnt; m_pch = m_ch; m_open = 0;
        end
        m_idle = 0;
      end else if (m_open != 0) begin
        if (m_idle < 255) m_idle++;
        if (tmo != 0 && m_idle >= int'(tmo)) m_err[4] = 1;
      end else m_idle = 0;
    end
  endtask

  task automatic compare_all();
    chk("R3 done", int'(pkt_done), m_done);
    chk("R2/R3 len", int'(pkt_len), m_len);
    chk("R3 chan", int'(pkt_chan), m_pch);
    chk("R4 dup", int'(proto_err[0]), int'(m_err[0]));
    chk("R5 stray", int'(proto_err[1]), int'(m_err[1]));
    chk("R6 chg", int'(proto_err[2]), int'(m_err[2]));
    chk("R7 ovr", int'(proto_err[3]), int'(m_err[3]));
    chk("R8 stall", int'(proto_err[4]), int'(m_err[4]));
  endtask

  task automatic cyc(input bit iv, input bit ir, input bit is, input bit ie,
                     input int iemp, input int ich);
    v = iv; r = ir; s = is; e = ie; emp = 2'(iemp); ch = 3'(ich);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1;
    idle(2);
    rst = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10: reset with stray traffic raises nothing
    rst = 1;
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 7);
    cyc(1, 1, 0, 0, 0, 3);
    rst = 0;
    idle(1);
    // R1, R2: three beats, one ignored by ready low, empty ignored mid-packet
    cyc(1, 1, 1, 0, 3, 2);
    cyc(1, 0, 0, 0, 0, 2);
    cyc(1, 1, 0, 0, 2, 2);
    cyc(1, 1, 0, 1, 1, 2);
    idle(2);
    // R2: single beat with empty 3 gives one byte; back-to-back packets
    cyc(1, 1, 1, 1, 3, 4);
    cyc(1, 1, 1, 1, 0, 1);
    cyc(1, 1, 1, 0, 0, 5);
    cyc(1, 1, 0, 1, 2, 5);
    // R8 disabled: long stall, limit zero
    tmo = 0;
    cyc(1, 1, 1, 0, 0, 3);
    idle(20);
    cyc(1, 1, 0, 1, 0, 3);
    // R9: stall one short of the limit, then cleared by a beat
    tmo = 4;
    cyc(1, 1, 1, 0, 0, 1);
    idle(3);
    cyc(1, 1, 0, 0, 0, 1);
    idle(3);
    cyc(1, 1, 0, 0, 0, 1);
    // R8: stall reaches the limit exactly
    idle(4);
    cyc(1, 1, 0, 1, 0, 1);
    idle(3);
    tmo = 0;
    // R5 then R10 stickiness across good traffic
    do_reset();
    cyc(1, 1, 0, 1, 0, 0);
    cyc(1, 1, 1, 1, 0, 0);
    idle(2);
    // R4: duplicate start restarts the count
    do_reset();
    cyc(1, 1, 1, 0, 0, 2);
    cyc(1, 1, 1, 0, 0, 2);
    cyc(1, 1, 0, 1, 1, 2);
    idle(1);
    // R6: channel change mid-packet
    do_reset();
    cyc(1, 1, 1, 0, 0, 3);
    cyc(1, 1, 0, 1, 0, 4);
    idle(1);
    // R7: channel above the maximum; channel 5 itself is fine
    do_reset();
    cyc(1, 1, 1, 1, 0, 5);
    idle(1);
    cyc(1, 1, 1, 1, 0, 6);
    idle(2);
    // R10: reset clears sticky bits
    do_reset();
    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule